// File: doc/BRIEF.md
# Strap-latched LED output controller

This block owns a small group of pins that have two jobs. While the synchronous reset is held, the pins are read as configuration straps, and the value they carry is kept as the 5-bit management address of the device. Once reset ends, the same pins become status LED drivers. The pads stay undriven until the stored straps are known to be settled.

Each pin's active level comes from the strap value stored on that pin. A pin that was strapped high pulls its LED low when lit, and a pin strapped low drives high when lit. An unlit pin therefore sits at its own strap level and never fights the strap resistor. An all-zero address requests power-down. Any other address, from 00001b to 11111b, is a valid address on a shared management bus.

Top module: `strap_led_ctrl`

## Requirements
- R1: At every rising clock edge with `rst` high, `mgmt_addr` takes the value of `pin_in`. After release, `mgmt_addr` equals the `pin_in` value sampled at the last rising edge that had `rst` high.
- R2: While `rst` is low, `mgmt_addr` does not change, whatever `pin_in` does.
- R3: `pin_oe` is all zeros while `rst` is high and stays all zeros through the first rising edge after release. It becomes all ones at the second rising edge after release and stays all ones until the next reset.
- R4: Polarity is set per pin by the stored address bit. A bit of 1 drives 0 when the LED is lit. A bit of 0 drives 1 when lit. An unlit pin drives the value of its own address bit.
- R5: Each pin has a fixed meaning, and `pin_out` shows the status sampled at the previous rising edge, so it lags one cycle. Bit 0 shows link up, bit 1 shows 100 Mb/s speed, bit 2 shows full duplex, bit 3 shows activity (`tx_act` or `rx_act`), and bit 4 shows collision.
- R6: `pwr_down` is 0 while `rst` is high. From the first rising edge after release, it is 1 when `mgmt_addr` is 00000b.
- R7: With any nonzero `mgmt_addr`, `pwr_down` is 0 after release.
- R8: `pin_out` is all zeros while reset is applied, that is, after any rising edge with `rst` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; straps are sampled while it is high |
| pin_in | input | 5 | Value read from the shared pads |
| link_up | input | 1 | Link established |
| speed_100 | input | 1 | Link runs at 100 Mb/s |
| full_duplex | input | 1 | Link is full duplex |
| tx_act | input | 1 | Transmit activity |
| rx_act | input | 1 | Receive activity |
| collision | input | 1 | Collision seen |
| pin_out | output | 5 | Value driven onto the pads |
| pin_oe | output | 5 | Pad output enables |
| mgmt_addr | output | 5 | Stored strap address |
| pwr_down | output | 1 | Power-down request for an all-zero address |

## Verification
Two events can fall in the same cycle: the reset release edge, which closes the strap sample, and a change on the pads and status inputs, which must not reach the address. The bench changes `pin_in` and every status input in the cycle right after the reset is released. It then checks that `mgmt_addr` still holds the last sample taken under reset, and that `pin_out` already reflects the new status with the stored polarity. A per-clock reference model judges every output on every cycle. It is run across several strap values (all zeros, all ones, mixed, and a single one) and across a reset pulse only one cycle long.

// File: rtl/strap_led_pkg.sv
package strap_led_pkg;
  localparam int unsigned ADDR_W  = 5;
  localparam int unsigned FUNC_CNT = 5;

  typedef enum logic [2:0] {
    FN_LINK   = 3'd0,
    FN_SPEED  = 3'd1,
    FN_DUPLEX = 3'd2,
    FN_ACT    = 3'd3,
    FN_COLL   = 3'd4
  } led_fn_e;

  typedef struct packed {
    logic coll;
    logic act;
    logic duplex;
    logic speed;
    logic link;
  } led_status_t;

  function automatic led_fn_e fn_of_pin(input int unsigned idx);
    return led_fn_e'(idx % FUNC_CNT);
  endfunction
endpackage

// File: rtl/strap_capture.sv
module strap_capture #(
  parameter int unsigned PIN_CNT = 5
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [PIN_CNT-1:0] pin_in,
  output logic [PIN_CNT-1:0] strap_q
);
  always_ff @(posedge clk) begin
    if (rst) strap_q <= pin_in;
  end

  a_r1_sample_at_release: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> strap_q == $past(pin_in));

  a_r2_addr_hold: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> $stable(strap_q));
endmodule

// File: rtl/drive_sequencer.sv
module drive_sequencer #(
  parameter int unsigned PIN_CNT = 5
) (
  input  logic               clk,
  input  logic               rst,
  output logic [PIN_CNT-1:0] oe_q
);
  logic armed_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      armed_q <= 1'b0;
      oe_q    <= '0;
    end else begin
      armed_q <= 1'b1;
      oe_q    <= {PIN_CNT{armed_q}};
    end
  end

  a_r3_off_after_release: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> oe_q == '0);

  a_r3_uniform: assert property (@(posedge clk) disable iff (rst)
    (oe_q == '0) || (oe_q == '1));
endmodule

// File: rtl/led_drive.sv
module led_drive
  import strap_led_pkg::*;
#(
  parameter int unsigned PIN_CNT = 5
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [PIN_CNT-1:0] strap,
  input  led_status_t        status,
  output logic [PIN_CNT-1:0] out_q
);
  logic [FUNC_CNT-1:0] stat_vec;
  logic [PIN_CNT-1:0]  lit;

  assign stat_vec = status;

  for (genvar i = 0; i < PIN_CNT; i++) begin : g_pin
    localparam led_fn_e FN = fn_of_pin(i);
    assign lit[i] = stat_vec[FN];
  end

  always_ff @(posedge clk) begin
    if (rst) out_q <= '0;
    else     out_q <= strap ^ lit;
  end

  a_r8_quiet_in_reset: assert property (@(posedge clk)
    $past(rst) && !rst |-> out_q == '0);

  a_r4_coll_idle_level: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && !$past(status.coll) |-> out_q[PIN_CNT-1] == strap[PIN_CNT-1]);

  a_r5_link_lit: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && $past(status.link) |-> out_q[0] != strap[0]);
endmodule

// File: rtl/strap_led_ctrl.sv
module strap_led_ctrl
  import strap_led_pkg::*;
#(
  parameter int unsigned PIN_CNT = ADDR_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [PIN_CNT-1:0] pin_in,
  input  logic               link_up,
  input  logic               speed_100,
  input  logic               full_duplex,
  input  logic               tx_act,
  input  logic               rx_act,
  input  logic               collision,
  output logic [PIN_CNT-1:0] pin_out,
  output logic [PIN_CNT-1:0] pin_oe,
  output logic [PIN_CNT-1:0] mgmt_addr,
  output logic               pwr_down
);
  led_status_t stat;
  logic        pd_q;

  assign stat.link   = link_up;
  assign stat.speed  = speed_100;
  assign stat.duplex = full_duplex;
  assign stat.act    = tx_act | rx_act;
  assign stat.coll   = collision;

  strap_capture #(.PIN_CNT(PIN_CNT)) u_cap (
    .clk(clk), .rst(rst), .pin_in(pin_in), .strap_q(mgmt_addr)
  );

  drive_sequencer #(.PIN_CNT(PIN_CNT)) u_seq (
    .clk(clk), .rst(rst), .oe_q(pin_oe)
  );

  led_drive #(.PIN_CNT(PIN_CNT)) u_drv (
    .clk(clk), .rst(rst), .strap(mgmt_addr), .status(stat), .out_q(pin_out)
  );

  always_ff @(posedge clk) begin
    if (rst) pd_q <= 1'b0;
    else     pd_q <= (mgmt_addr == '0);
  end
  assign pwr_down = pd_q;

  a_r6_pd_zero_addr: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && (mgmt_addr == '0) |-> pwr_down);

  a_r7_no_pd_nonzero: assert property (@(posedge clk) disable iff (rst)
    (mgmt_addr != '0) |-> !pwr_down);
endmodule

// File: tb/strap_led_ctrl_bench.sv
`timescale 1ns/1ps
module strap_led_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [4:0] pin_in = 5'b0;
  logic       link_up = 0, speed_100 = 0, full_duplex = 0, tx_act = 0, rx_act = 0, collision = 0;
  logic [4:0] pin_out, pin_oe, mgmt_addr;
  logic       pwr_down;

  int total = 0;
  int bad   = 0;
  bit started = 0;
  bit done = 0;

  // reference model state
  logic [4:0] m_addr, m_out, m_oe;
  logic       m_pd;
  int         m_since_rel;

  always #2.5 clk = ~clk;

  strap_led_ctrl u_strap_led_ctrl (
    .clk(clk), .rst(rst), .pin_in(pin_in),
    .link_up(link_up), .speed_100(speed_100), .full_duplex(full_duplex),
    .tx_act(tx_act), .rx_act(rx_act), .collision(collision),
    .pin_out(pin_out), .pin_oe(pin_oe), .mgmt_addr(mgmt_addr), .pwr_down(pwr_down)
  );

  always @(posedge clk) begin
    logic [4:0] lit;
    started <= 1'b1;
    if (rst) begin
      m_addr = pin_in;
      m_since_rel = 0;
      m_out = 5'b0;
      m_oe = 5'b0;
      m_pd = 1'b0;
    end else begin
      m_since_rel = m_since_rel + 1;
      lit[0] = link_up;
      lit[1] = speed_100;
      lit[2] = full_duplex;
      lit[3] = tx_act || rx_act;
      lit[4] = collision;
      for (int b = 0; b < 5; b++)
        m_out[b] = m_addr[b] ? ~lit[b] : lit[b];
      m_oe = (m_since_rel >= 2) ? 5'b11111 : 5'b00000;
      m_pd = (m_addr == 5'b0);
    end
  end

  task automatic chk(input string req, input logic [4:0] act, input logic [4:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (started && !done) begin
      chk(rst ? "R1" : "R2", mgmt_addr, m_addr);
      chk("R3", pin_oe, m_oe);
      chk(rst ? "R8" : "R4,R5", pin_out, m_out);
      chk(m_addr == 5'b0 ? "R6" : "R7", {4'b0, pwr_down}, {4'b0, m_pd});
    end
  end

  task automatic drive_status();
    {link_up, speed_100, full_duplex, tx_act, rx_act, collision} = 6'($urandom);
  endtask

  task automatic run_phase(input logic [4:0] strap, input int rst_cycles, input int run_cycles);
    @(negedge clk);
    rst = 1'b1;
    pin_in = strap;
    repeat (rst_cycles) @(negedge clk);
    rst = 1'b0;
    // R2: pads and status change right after release; address must hold
    pin_in = ~strap;
    drive_status();
    for (int c = 0; c < run_cycles; c++) begin
      @(negedge clk);
      pin_in = 5'($urandom);
      drive_status();
    end
  endtask

  initial begin
    fork
      begin
        run_phase(5'b10110, 3, 40);
        run_phase(5'b00000, 2, 30);   // R6 power-down
        run_phase(5'b11111, 4, 30);   // R4 all active-low
        run_phase(5'b00001, 1, 30);   // R7 lowest valid address, short reset
        // R1: strap changes during reset, last sample wins
        @(negedge clk); rst = 1'b1; pin_in = 5'b01010;
        @(negedge clk); pin_in = 5'b10101;
        @(negedge clk); rst = 1'b0; pin_in = 5'b00000;
        repeat (20) begin @(negedge clk); drive_status(); end
        @(negedge clk);
      end
      begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
      end
    join_any
    done = 1'b1;
    if (total < 12) begin total++; bad++; $display("FAIL checks actual=%0d expected>=12", total); end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule